// File: doc/BRIEF.md
# Parallel Windowed Image Fetch DMA

This block is the fetch and write-back engine for a bank of eight 3x3 correlation lanes working on a 512x512 image of 16-bit pixels. Before a pass, a controller writes each lane's first window centre as a pixel index (row times 512 plus column). The controller also drives a base address for the source image and a base address for the result image. A start pulse then runs a pass. For every window centre, one shared sequencer steps through the nine neighbourhood offsets in row-major order. Every lane reads the pixel at the same offset in the same cycle, so the nth window value reaches all eight lanes together.

The memory answers each read one cycle later, and the engine strobes the lanes to load the returned pixels in that cycle. Once the ninth pixel is in, the engine waits for the lanes' arithmetic latency and captures all eight results. It then writes them back in lane order over eight consecutive cycles, at the result base plus the centre's pixel index, so the result image keeps the row-after-row layout of the source. The centres then move one column to the right. Border pixels are never centres: a pass visits columns 1 to 510. After the last write of the last column the engine raises a done flag.

The correlation arithmetic sits outside the block and is reached through the lane load strobe, tap number, pixel bus and result bus. Covering the whole image takes 64 passes of eight rows each.

Top module: `win_fetch_dma`

## Requirements
- R1: After reset, rd_en, wr_en, lane_load and done are all 0.
- R2: While the engine is idle, a cycle with cfg_we high stores cfg_idx as the first centre pixel index of the lane selected by cfg_lane (index = row*512 + column). The next pass uses that value.
- R3: Each window takes nine consecutive read cycles with rd_en high. In the read cycle for tap k (k = 0..8), every lane's rd_addr equals img_base + centre + (k/3 - 1)*512 + (k%3 - 1), so all lanes fetch the same tap in the same cycle.
- R4: One cycle after each read cycle, lane_load is high, lane_tap carries that read's tap number k, and each lane's lane_pix slice carries the pixel returned for that lane's read.
- R5: Each window moves every lane's centre one column to the right. A pass holds exactly 510 windows, and no read address falls outside the image.
- R6: Lane results are captured CORR_LAT cycles after the load of tap 8. Each written value is the result that the lane presented for the window just completed.
- R7: After each capture come eight consecutive write cycles in lane order 0 to 7. The write for lane l has wr_addr = res_base + that lane's centre index and wr_data = lane l's captured result. The next window's first read follows in the next cycle.
- R8: wr_en is high only in those write cycles and never in the same cycle as rd_en, so no partial window is ever stored.
- R9: done rises in the cycle after the last write of column 510 and stays high while the engine is idle, with no read, load or write strobe. It clears when the next start is accepted.
- R10: A start pulse during a running pass is ignored, and the pass continues on its schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a pass when the engine is idle |
| cfg_we | input | 1 | Write strobe for a lane's first centre index |
| cfg_lane | input | 3 | Lane selected by cfg_we |
| cfg_idx | input | 18 | First centre pixel index for that lane |
| img_base | input | 20 | Source image base address |
| res_base | input | 20 | Result image base address |
| rd_en | output | 1 | Read strobe, the same for all lanes |
| rd_addr | output | 160 | Read address per lane, lane l at bits [20l+19:20l] |
| rd_data | input | 128 | Read data per lane, one cycle after rd_en, lane l at bits [16l+15:16l] |
| lane_load | output | 1 | Pixel load strobe to all lanes |
| lane_tap | output | 4 | Window tap number (0..8) of the loaded pixel |
| lane_pix | output | 128 | Pixel per lane, lane l at bits [16l+15:16l] |
| lane_res | input | 256 | Correlation result per lane, lane l at bits [32l+31:32l] |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | 20 | Result write address |
| wr_data | output | 32 | Result write data |
| done | output | 1 | Pass finished |

## Verification
Let cycle 0 be the cycle after the clock edge that accepts start, and let each window take 19 cycles with phase p = t mod 19. Then reads fall on phases 0 to 8 of column t div 19, lane loads on phases 1 to 9 with tap p-1, and result writes on phases 11 to 18 for lane p-11. done is due at cycle 510*19. The bench runs a behavioural reference of this timetable and compares every strobe, address, pixel and result against it on the falling edge of every cycle. So a result arriving one cycle early or late shows up as a mismatch at that exact cycle. The expected results come from the bench's own pixel function and mask, passed through a bench-side correlator model that registers its sum on the tap-8 load.

// File: rtl/win_dma_pkg.sv
package win_dma_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_WAIT,
    S_WRITE
  } seq_state_e;

  // Signed address offset of window tap (row-major over dy, dx in -1..+1)
  function automatic int tap_offset(input int tap, input int row_len);
    int dy;
    int dx;
    dy = (tap / 3) - 1;
    dx = (tap % 3) - 1;
    return dy * row_len + dx;
  endfunction

endpackage

// File: rtl/win_seq.sv
module win_seq
  import win_dma_pkg::*;
#(
  parameter int LANES    = 8,
  parameter int COLS     = 510,
  parameter int CORR_LAT = 1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  output logic                                   begin_pass,
  output logic                                   fetch,
  output logic [3:0]                             tap,
  output logic                                   load_q,
  output logic [3:0]                             load_tap,
  output logic                                   cap_stb,
  output logic                                   wr_phase,
  output logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0] wr_lane,
  output logic                                   col_step,
  output logic                                   done
);

  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int LAT_W  = $clog2(CORR_LAT + 1) + 1;
  localparam int LAST_TAP = 8;

  seq_state_e          st;
  logic [3:0]          tap_q;
  logic [LAT_W-1:0]    wcnt;
  logic [LANE_W-1:0]   lane_q;
  logic [COL_W-1:0]    col_q;
  logic                done_q;
  logic                load_r;
  logic [3:0]          ltap_r;

  // Named events used by the datapath and by the assertions
  logic last_tap, last_wait, last_lane, last_col, pass_end;

  assign last_tap   = (tap_q == 4'(LAST_TAP));
  assign last_wait  = (wcnt == LAT_W'(CORR_LAT));
  assign last_lane  = (lane_q == LANE_W'(LANES - 1));
  assign last_col   = (col_q == COL_W'(COLS - 1));
  assign begin_pass = (st == S_IDLE) && start;
  assign fetch      = (st == S_FETCH);
  assign cap_stb    = (st == S_WAIT) && last_wait;
  assign wr_phase   = (st == S_WRITE);
  assign col_step   = wr_phase && last_lane && !last_col;
  assign pass_end   = wr_phase && last_lane && last_col;

  assign tap      = tap_q;
  assign load_q   = load_r;
  assign load_tap = ltap_r;
  assign wr_lane  = lane_q;
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tap_q  <= '0;
      wcnt   <= '0;
      lane_q <= '0;
      col_q  <= '0;
      done_q <= 1'b0;
      load_r <= 1'b0;
      ltap_r <= '0;
    end else begin
      load_r <= (st == S_FETCH);
      ltap_r <= tap_q;
      if (begin_pass)    done_q <= 1'b0;
      else if (pass_end) done_q <= 1'b1;
      case (st)
        S_IDLE: begin
          if (start) begin
            st    <= S_FETCH;
            tap_q <= '0;
            col_q <= '0;
          end
        end
        S_FETCH: begin
          if (last_tap) begin
            st   <= S_WAIT;
            wcnt <= '0;
          end else begin
            tap_q <= tap_q + 4'd1;
          end
        end
        S_WAIT: begin
          if (last_wait) begin
            st     <= S_WRITE;
            lane_q <= '0;
          end else begin
            wcnt <= wcnt + LAT_W'(1);
          end
        end
        S_WRITE: begin
          if (last_lane) begin
            tap_q <= '0;
            if (last_col) begin
              st <= S_IDLE;
            end else begin
              st    <= S_FETCH;
              col_q <= col_q + COL_W'(1);
            end
          end else begin
            lane_q <= lane_q + LANE_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_TAP_SEQUENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_r && ltap_r != 4'd0) |-> ($past(load_r) && $past(ltap_r) == ltap_r - 4'd1)); // R3
  AST_COL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    col_q < COL_W'(COLS)); // R5
  AST_WRITE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_phase && lane_q == '0) |-> $past(cap_stb)); // R6

endmodule

// File: rtl/win_lane.sv
module win_lane
  import win_dma_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int IDX_W   = 18,
  parameter int LANE_W  = 3,
  parameter int LANE_ID = 0,
  parameter int ROW_LEN = 512,
  parameter int IMG_PIX = 262144
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [LANE_W-1:0] cfg_lane,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              begin_pass,
  input  logic              col_step,
  input  logic              fetch,
  input  logic [3:0]        tap,
  input  logic [ADDR_W-1:0] img_base,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [IDX_W-1:0]  centre
);

  logic [IDX_W-1:0]  first_q;
  logic [IDX_W-1:0]  centre_q;
  logic [ADDR_W-1:0] rel_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q  <= '0;
      centre_q <= '0;
    end else begin
      if (cfg_we && cfg_lane == LANE_W'(LANE_ID)) first_q <= cfg_idx;
      if (begin_pass)    centre_q <= first_q;
      else if (col_step) centre_q <= centre_q + IDX_W'(1);
    end
  end

  assign rel_addr = ADDR_W'(centre_q) + ADDR_W'(tap_offset(int'(tap), ROW_LEN));
  assign rd_addr  = img_base + rel_addr;
  assign centre   = centre_q;

  AST_RD_IN_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> ((rd_addr - img_base) < ADDR_W'(IMG_PIX))); // R5

endmodule

// File: rtl/win_bank.sv
module win_bank #(
  parameter int LANES  = 8,
  parameter int RES_W  = 32,
  parameter int ADDR_W = 20,
  parameter int IDX_W  = 18,
  parameter int LANE_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_stb,
  input  logic [LANES*RES_W-1:0]  lane_res,
  input  logic                    wr_phase,
  input  logic [LANE_W-1:0]       wr_lane,
  input  logic [LANES*IDX_W-1:0]  centres,
  input  logic [ADDR_W-1:0]       res_base,
  output logic                    wr_en,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [RES_W-1:0]        wr_data
);

  logic [RES_W-1:0] cap_q [LANES];
  logic [IDX_W-1:0] sel_centre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LANES; i++) cap_q[i] <= '0;
    end else if (cap_stb) begin
      for (int i = 0; i < LANES; i++) cap_q[i] <= lane_res[i*RES_W +: RES_W];
    end
  end

  assign sel_centre = centres[wr_lane*IDX_W +: IDX_W];
  assign wr_en      = wr_phase;
  assign wr_addr    = res_base + ADDR_W'(sel_centre);
  assign wr_data    = cap_q[wr_lane];

  AST_WR_LANE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_phase && wr_lane != '0) |-> ($past(wr_phase) && $past(wr_lane) == wr_lane - LANE_W'(1))); // R7

endmodule

// File: rtl/win_fetch_dma.sv
module win_fetch_dma #(
  parameter int LANES    = 8,
  parameter int IMG_W    = 512,
  parameter int IMG_H    = 512,
  parameter int PIX_W    = 16,
  parameter int RES_W    = 32,
  parameter int ADDR_W   = 20,
  parameter int CORR_LAT = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    cfg_we,
  input  logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0] cfg_lane,
  input  logic [$clog2(IMG_W*IMG_H)-1:0] cfg_idx,
  input  logic [ADDR_W-1:0]       img_base,
  input  logic [ADDR_W-1:0]       res_base,
  output logic                    rd_en,
  output logic [LANES*ADDR_W-1:0] rd_addr,
  input  logic [LANES*PIX_W-1:0]  rd_data,
  output logic                    lane_load,
  output logic [3:0]              lane_tap,
  output logic [LANES*PIX_W-1:0]  lane_pix,
  input  logic [LANES*RES_W-1:0]  lane_res,
  output logic                    wr_en,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [RES_W-1:0]        wr_data,
  output logic                    done
);

  localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int IMG_PIX = IMG_W * IMG_H;
  localparam int IDX_W   = $clog2(IMG_PIX);
  localparam int COLS    = IMG_W - 2;

  logic              begin_pass, fetch, cap_stb, wr_phase, col_step;
  logic [3:0]        tap;
  logic [LANE_W-1:0] wr_lane;
  logic [LANES*IDX_W-1:0] centres;

  win_seq #(
    .LANES(LANES), .COLS(COLS), .CORR_LAT(CORR_LAT)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .begin_pass(begin_pass), .fetch(fetch), .tap(tap),
    .load_q(lane_load), .load_tap(lane_tap), .cap_stb(cap_stb),
    .wr_phase(wr_phase), .wr_lane(wr_lane), .col_step(col_step),
    .done(done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    win_lane #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LANE_W(LANE_W), .LANE_ID(g),
      .ROW_LEN(IMG_W), .IMG_PIX(IMG_PIX)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lane(cfg_lane),
      .cfg_idx(cfg_idx), .begin_pass(begin_pass), .col_step(col_step),
      .fetch(fetch), .tap(tap), .img_base(img_base),
      .rd_addr(rd_addr[g*ADDR_W +: ADDR_W]),
      .centre(centres[g*IDX_W +: IDX_W])
    );
  end

  win_bank #(
    .LANES(LANES), .RES_W(RES_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LANE_W(LANE_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .lane_res(lane_res),
    .wr_phase(wr_phase), .wr_lane(wr_lane), .centres(centres),
    .res_base(res_base), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign rd_en    = fetch;
  assign lane_pix = rd_data;

  AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en)); // R8
  AST_LOAD_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    lane_load |-> $past(rd_en)); // R4
  AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!rd_en && !wr_en && !lane_load)); // R9

endmodule

// File: tb/win_fetch_dma_bench.sv
module win_fetch_dma_bench;

  localparam int LANES = 8;
  localparam int W     = 512;
  localparam int AW    = 20;
  localparam int PW    = 16;
  localparam int RW    = 32;
  localparam int COLS  = W - 2;
  localparam int PER   = 9 + 1 + 1 + LANES;   // reads, latency, correlator, writes
  localparam int TOTAL = COLS * PER;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_lane = '0;
  logic [17:0] cfg_idx = '0;
  logic [AW-1:0] img_base = '0;
  logic [AW-1:0] res_base = '0;
  logic rd_en, lane_load, wr_en, done;
  logic [LANES*AW-1:0] rd_addr;
  logic [LANES*PW-1:0] rd_data = '0;
  logic [LANES*PW-1:0] lane_pix;
  logic [LANES*RW-1:0] lane_res;
  logic [3:0] lane_tap;
  logic [AW-1:0] wr_addr;
  logic [RW-1:0] wr_data;

  int total = 0;
  int bad = 0;
  int first_idx [LANES];
  int mask [9];
  int acc [LANES];
  int res_q [LANES];

  always #10 clk = ~clk;

  win_fetch_dma u_win_fetch_dma (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_we(cfg_we),
    .cfg_lane(cfg_lane), .cfg_idx(cfg_idx), .img_base(img_base),
    .res_base(res_base), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .lane_load(lane_load), .lane_tap(lane_tap), .lane_pix(lane_pix),
    .lane_res(lane_res), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done)
  );

  function automatic logic [15:0] pixf(input int i);
    return 16'((i * 37 + (i >> 4) * 5 + 11) % 65536);
  endfunction

  function automatic int nb_off(input int k);
    return (k / 3) * W + (k % 3) - W - 1;
  endfunction

  function automatic int exp_corr(input int s, input int c);
    int sum = 0;
    for (int k = 0; k < 9; k++) sum += mask[k] * int'(pixf(s + c + nb_off(k)));
    return sum;
  endfunction

  // Memory model: one-cycle read latency
  always @(posedge clk) begin
    if (rd_en)
      for (int l = 0; l < LANES; l++)
        rd_data[l*PW +: PW] <= pixf(int'(rd_addr[l*AW +: AW]) - int'(img_base));
  end

  // Correlation lane model: result registered on the tap-8 load
  always @(posedge clk) begin
    if (lane_load)
      for (int l = 0; l < LANES; l++) begin
        int term;
        term = mask[lane_tap] * int'(lane_pix[l*PW +: PW]);
        if (lane_tap == 4'd0) acc[l] <= term;
        else acc[l] <= acc[l] + term;
        if (lane_tap == 4'd8) res_q[l] <= acc[l] + term;
      end
  end

  always_comb
    for (int l = 0; l < LANES; l++) lane_res[l*RW +: RW] = RW'(res_q[l]);

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic check_cycle(input int t);
    int c = t / PER;
    int p = t % PER;
    if (t < TOTAL) begin
      chk("R3", "rd_en", rd_en, p < 9);
      if (p < 9)
        for (int l = 0; l < LANES; l++)
          chk((c == COLS - 1) ? "R5" : "R3", "rd_addr",
              rd_addr[l*AW +: AW], int'(img_base) + first_idx[l] + c + nb_off(p));
      chk("R4", "lane_load", lane_load, (p >= 1 && p <= 9));
      if (p >= 1 && p <= 9) begin
        chk("R4", "lane_tap", lane_tap, p - 1);
        for (int l = 0; l < LANES; l++)
          chk("R4", "lane_pix", lane_pix[l*PW +: PW],
              pixf(first_idx[l] + c + nb_off(p - 1)));
      end
      chk("R8", "wr_en", wr_en, p >= 11);
      if (p >= 11) begin
        chk("R7", "wr_addr", wr_addr, int'(res_base) + first_idx[p-11] + c);
        chk("R6", "wr_data", wr_data, exp_corr(first_idx[p-11], c));
      end
      chk("R9", "done_low", done, 0);
    end else begin
      chk("R9", "done_high", done, 1);
      chk("R9", "rd_en_idle", rd_en, 0);
      chk("R9", "wr_en_idle", wr_en, 0);
      chk("R9", "load_idle", lane_load, 0);
    end
  endtask

  task automatic configure(input int rows [LANES]);
    for (int l = 0; l < LANES; l++) begin
      first_idx[l] = rows[l] * W + 1;
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_lane = 3'(l);
      cfg_idx = 18'(first_idx[l]);
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_pass(input bit poke);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "lane7_first_addr", rd_addr[7*AW +: AW],
        int'(img_base) + first_idx[7] + nb_off(0));
    for (int t = 0; t <= TOTAL; t++) begin
      check_cycle(t);
      if (poke && t == 300) start = 1'b1;
      if (poke && t == 301) start = 1'b0;
      if (poke && t == 305) chk("R10", "rd_en_after_poke", rd_en, (t % PER) < 9);
      if (t < TOTAL) @(negedge clk);
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_cycle(TOTAL);
    end
  endtask

  initial begin
    int rows1 [LANES];
    int rows2 [LANES];
    repeat (3) @(negedge clk);
    chk("R1", "rd_en_rst", rd_en, 0);
    chk("R1", "wr_en_rst", wr_en, 0);
    chk("R1", "load_rst", lane_load, 0);
    chk("R1", "done_rst", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "done_after_rst", done, 0);
    chk("R1", "rd_en_after_rst", rd_en, 0);

    // Pass 1: rows 1..8, symmetric mask
    for (int l = 0; l < LANES; l++) rows1[l] = l + 1;
    mask = '{1, 2, 1, 2, 4, 2, 1, 2, 1};
    img_base = 20'h00000;
    res_base = 20'h40000;
    configure(rows1);
    run_pass(1'b0);

    // Pass 2: bottom rows in reverse lane order, new bases, mask, mid-pass start
    for (int l = 0; l < LANES; l++) rows2[l] = 510 - l;
    mask = '{3, 1, 4, 1, 5, 9, 2, 6, 5};
    img_base = 20'h20000;
    res_base = 20'h80000;
    configure(rows2);
    run_pass(1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule